// File: doc/BRIEF.md
# Cross-Stream Common Operand Detector

The block sits in front of three redundant processing elements that are not run in lockstep. Each element is fed from its own stream of 32-bit operand words through a first-in first-out buffer. The buffers can also be searched by content. When an element takes the word at the head of its stream, the block checks whether the same word is still waiting in either of the other two buffers. A match marks a chance to compare all three elements on one operand, even though they meet it at different times.

Each such operand is held in a small pending cache. As the elements finish, the surrounding logic hands each result back together with the operand it belongs to. The block files every result under the matching pending operand. Once all three results are present, the block issues the operand and the three aligned results as a one-cycle vote request, and it frees the cache slot. The voting arithmetic and the elements themselves sit outside the block.

Top module: `common_operand_detect`

## Requirements
- R1: Each stream's words leave on `pe_data_o` in the order they were accepted. A word is removed on a cycle where `pe_valid_o` and `pe_ready_i` are both high, and `pe_valid_o` is low when the buffer is empty.
- R2: `in_ready_o` of a stream drops once its buffer holds DEPTH words (default 32). A word offered while `in_ready_o` is low is dropped and never appears on the output.
- R3: `hit_o[k]` is high in the cycle stream k removes a word that equals a word still held in the buffer of another stream. It stays low if the word is held only in stream k's own buffer, or only in buffers that have already released it.
- R4: Searching does not alter any buffer. A word that matched a search later leaves its own buffer unchanged and in order.
- R5: A hit on an operand that is not pending takes the lowest free slot of the pending cache (default 4 slots). A later `res_valid_i[k]` whose `res_op_i[k]` equals a pending operand stores `res_data_i[k]` as stream k's result for that operand.
- R6: On the clock edge after the third result of a pending operand is stored, `vote_valid_o` is high for one cycle. It carries the operand on `vote_op_o` and stream k's result in `vote_res_o[k]`.
- R7: A result whose operand is not pending, or that arrives for a stream whose result for that operand is already stored, changes nothing; the first stored value is kept.
- R8: A hit on a non-pending operand while all slots are occupied allocates nothing. It raises `ovf_cnt_o` by one, and the count saturates at 2^OVF_W-1.
- R9: A hit on an operand already pending, or on the same operand as a lower-numbered stream hitting in the same cycle, allocates no second slot and does not count as overflow.
- R10: A slot is freed by the edge that issues its vote and can be allocated again afterwards.
- R11: After reset all buffers are empty, no operand is pending, `vote_valid_o` is low and `ovf_cnt_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | NS | Per-stream operand offer |
| in_data_i | input | NS x W | Per-stream operand word |
| in_ready_o | output | NS | Per-stream buffer has room |
| pe_valid_o | output | NS | Head word available to element k |
| pe_data_o | output | NS x W | Head word of stream k |
| pe_ready_i | input | NS | Element k takes the head word |
| hit_o | output | NS | Removed word found in another buffer |
| res_valid_i | input | NS | Element k delivers a result |
| res_op_i | input | NS x W | Operand the result belongs to |
| res_data_i | input | NS x W | Result word |
| vote_valid_o | output | 1 | Aligned triple ready, one cycle |
| vote_op_o | output | W | Common operand |
| vote_res_o | output | NS x W | Results, index k from stream k |
| ovf_cnt_o | output | OVF_W | Saturating count of hits lost to a full cache |

## Verification
The properties assume the element side never raises `pe_ready_i` expecting a transfer while `pe_valid_o` is low. They also assume each result is handed back at least one cycle after the hit that allocated its operand, so a result never races its own allocation. The directed tests keep this order: every removal is followed by its result in a later task, and same-cycle removals occur only in the duplicate test, where the results still follow. Pending operands are unique by construction of R9. The property on back-to-back votes depends on this, and the stimulus never injects a result for an operand outside the cache that it then expects to vote.

// File: rtl/cod_pkg.sv
package cod_pkg;
  localparam int unsigned NS_DEF    = 3;
  localparam int unsigned WORD_DEF  = 32;
  localparam int unsigned DEPTH_DEF = 32;
  localparam int unsigned SLOTS_DEF = 4;
  localparam int unsigned OVF_DEF   = 8;
endpackage

// File: rtl/cod_cam_fifo.sv
module cod_cam_fifo #(
  parameter int unsigned W     = cod_pkg::WORD_DEF,
  parameter int unsigned DEPTH = cod_pkg::DEPTH_DEF,
  parameter int unsigned NK    = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 push_i,
  input  logic [W-1:0]         data_i,
  output logic                 ready_o,
  input  logic                 pop_i,
  output logic                 valid_o,
  output logic [W-1:0]         head_o,
  input  logic [NK-1:0][W-1:0] key_i,
  output logic [NK-1:0]        match_o
);
  localparam int unsigned AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW  = AW + 1;

  logic [W-1:0]     mem_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [AW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;
  logic             push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign ready_o = (cnt_q != CW'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign head_o  = mem_q[rd_q];
  assign push_ok = push_i && ready_o;
  assign pop_ok  = pop_i && valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      vld_q <= '0;
    end else begin
      if (push_ok) begin
        vld_q[wr_q] <= 1'b1;
        wr_q        <= ptr_inc(wr_q);
      end
      if (pop_ok) begin
        vld_q[rd_q] <= 1'b0;
        rd_q        <= ptr_inc(rd_q);
      end
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= data_i;
  end

  // content search over live entries only
  for (genvar m = 0; m < NK; m++) begin : g_key
    always_comb begin
      match_o[m] = 1'b0;
      for (int e = 0; e < DEPTH; e++)
        if (vld_q[e] && (mem_q[e] == key_i[m])) match_o[m] = 1'b1;
    end
  end
endmodule

// File: rtl/cod_pend_cache.sv
module cod_pend_cache #(
  parameter int unsigned NS    = cod_pkg::NS_DEF,
  parameter int unsigned W     = cod_pkg::WORD_DEF,
  parameter int unsigned NE    = cod_pkg::SLOTS_DEF,
  parameter int unsigned OVF_W = cod_pkg::OVF_DEF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NS-1:0]        req_i,
  input  logic [NS-1:0][W-1:0] key_i,
  input  logic [NS-1:0]        res_valid_i,
  input  logic [NS-1:0][W-1:0] res_op_i,
  input  logic [NS-1:0][W-1:0] res_data_i,
  output logic                 vote_valid_o,
  output logic [W-1:0]         vote_op_o,
  output logic [NS-1:0][W-1:0] vote_res_o,
  output logic [OVF_W-1:0]     ovf_cnt_o
);
  localparam int unsigned EW      = (NE > 1) ? $clog2(NE) : 1;
  localparam int unsigned AW      = $clog2(NS + 1);
  localparam int          OVF_MAX = (1 << OVF_W) - 1;

  logic [NE-1:0]                 e_vld_q;
  logic [NE-1:0][W-1:0]          e_key_q;
  logic [NE-1:0][NS-1:0]         e_have_q;
  logic [NE-1:0][NS-1:0][W-1:0]  e_res_q;
  logic                          vote_valid_q;
  logic [W-1:0]                  vote_op_q;
  logic [NS-1:0][W-1:0]          vote_res_q;
  logic [OVF_W-1:0]              ovf_q, ovf_nxt;

  logic [NE-1:0]        free_v, alloc_en, full;
  logic [NE-1:0][W-1:0] alloc_key;
  logic [NE-1:0][NS-1:0] cap;
  logic [AW-1:0]        ovf_add;
  logic                 skip, placed, vany;
  logic [EW-1:0]        vsel;
  int                   sum;

  // allocation: one slot per distinct new operand, lowest free first
  always_comb begin
    free_v    = ~e_vld_q;
    alloc_en  = '0;
    alloc_key = '0;
    ovf_add   = '0;
    skip      = 1'b0;
    placed    = 1'b0;
    for (int k = 0; k < NS; k++) begin
      skip   = 1'b0;
      placed = 1'b0;
      for (int e = 0; e < NE; e++)
        if (e_vld_q[e] && (e_key_q[e] == key_i[k])) skip = 1'b1;
      for (int j = 0; j < k; j++)
        if (req_i[j] && (key_i[j] == key_i[k])) skip = 1'b1;
      if (req_i[k] && !skip) begin
        for (int e = 0; e < NE; e++) begin
          if (!placed && free_v[e]) begin
            placed       = 1'b1;
            free_v[e]    = 1'b0;
            alloc_en[e]  = 1'b1;
            alloc_key[e] = key_i[k];
          end
        end
        if (!placed) ovf_add = ovf_add + 1'b1;
      end
    end
  end

  always_comb begin
    sum     = int'(ovf_q) + int'(ovf_add);
    ovf_nxt = (sum > OVF_MAX) ? OVF_W'(OVF_MAX) : OVF_W'(sum);
  end

  always_comb begin
    for (int e = 0; e < NE; e++) begin
      full[e] = e_vld_q[e] && (&e_have_q[e]);
      for (int k = 0; k < NS; k++)
        cap[e][k] = e_vld_q[e] && !e_have_q[e][k] && res_valid_i[k] &&
                    (res_op_i[k] == e_key_q[e]);
    end
  end

  always_comb begin
    vany = |full;
    vsel = '0;
    for (int e = NE - 1; e >= 0; e--)
      if (full[e]) vsel = EW'(e);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e_vld_q      <= '0;
      e_key_q      <= '0;
      e_have_q     <= '0;
      e_res_q      <= '0;
      vote_valid_q <= 1'b0;
      vote_op_q    <= '0;
      vote_res_q   <= '0;
      ovf_q        <= '0;
    end else begin
      ovf_q        <= ovf_nxt;
      vote_valid_q <= vany;
      if (vany) begin
        vote_op_q  <= e_key_q[vsel];
        vote_res_q <= e_res_q[vsel];
      end
      for (int e = 0; e < NE; e++)
        for (int k = 0; k < NS; k++)
          if (cap[e][k]) begin
            e_have_q[e][k] <= 1'b1;
            e_res_q[e][k]  <= res_data_i[k];
          end
      if (vany) begin
        e_vld_q[vsel]  <= 1'b0;
        e_have_q[vsel] <= '0;
      end
      for (int e = 0; e < NE; e++)
        if (alloc_en[e]) begin
          e_vld_q[e]  <= 1'b1;
          e_key_q[e]  <= alloc_key[e];
          e_have_q[e] <= '0;
        end
    end
  end

  assign vote_valid_o = vote_valid_q;
  assign vote_op_o    = vote_op_q;
  assign vote_res_o   = vote_res_q;
  assign ovf_cnt_o    = ovf_q;
endmodule

// File: rtl/common_operand_detect.sv
module common_operand_detect #(
  parameter int unsigned NS    = cod_pkg::NS_DEF,
  parameter int unsigned W     = cod_pkg::WORD_DEF,
  parameter int unsigned DEPTH = cod_pkg::DEPTH_DEF,
  parameter int unsigned NE    = cod_pkg::SLOTS_DEF,
  parameter int unsigned OVF_W = cod_pkg::OVF_DEF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NS-1:0]        in_valid_i,
  input  logic [NS-1:0][W-1:0] in_data_i,
  output logic [NS-1:0]        in_ready_o,
  output logic [NS-1:0]        pe_valid_o,
  output logic [NS-1:0][W-1:0] pe_data_o,
  input  logic [NS-1:0]        pe_ready_i,
  output logic [NS-1:0]        hit_o,
  input  logic [NS-1:0]        res_valid_i,
  input  logic [NS-1:0][W-1:0] res_op_i,
  input  logic [NS-1:0][W-1:0] res_data_i,
  output logic                 vote_valid_o,
  output logic [W-1:0]         vote_op_o,
  output logic [NS-1:0][W-1:0] vote_res_o,
  output logic [OVF_W-1:0]     ovf_cnt_o
);
  localparam int unsigned NK = NS - 1;

  logic [NS-1:0]                  pop;
  logic [NS-1:0][NK-1:0][W-1:0]   keys;
  logic [NS-1:0][NK-1:0]          match;
  logic [NS-1:0]                  seen;

  assign pop = pe_valid_o & pe_ready_i;

  // buffer j searches for the heads of the other streams, slot m = stream (j+1+m)%NS
  for (genvar j = 0; j < NS; j++) begin : g_buf
    for (genvar m = 0; m < NK; m++) begin : g_k
      assign keys[j][m] = pe_data_o[(j + 1 + m) % NS];
    end
    cod_cam_fifo #(.W(W), .DEPTH(DEPTH), .NK(NK)) i_buf (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (in_valid_i[j]),
      .data_i  (in_data_i[j]),
      .ready_o (in_ready_o[j]),
      .pop_i   (pop[j]),
      .valid_o (pe_valid_o[j]),
      .head_o  (pe_data_o[j]),
      .key_i   (keys[j]),
      .match_o (match[j])
    );
  end

  always_comb begin
    seen = '0;
    for (int k = 0; k < NS; k++)
      for (int j = 0; j < NS; j++)
        if (j != k && match[j][(k - j - 1 + NS) % NS]) seen[k] = 1'b1;
  end

  assign hit_o = pop & seen;

  cod_pend_cache #(.NS(NS), .W(W), .NE(NE), .OVF_W(OVF_W)) i_cache (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (hit_o),
    .key_i        (pe_data_o),
    .res_valid_i  (res_valid_i),
    .res_op_i     (res_op_i),
    .res_data_i   (res_data_i),
    .vote_valid_o (vote_valid_o),
    .vote_op_o    (vote_op_o),
    .vote_res_o   (vote_res_o),
    .ovf_cnt_o    (ovf_cnt_o)
  );
endmodule

// File: rtl/cod_checks.sv
module cod_checks #(
  parameter int unsigned NS    = 3,
  parameter int unsigned W     = 32,
  parameter int unsigned OVF_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NS-1:0]    in_ready_o,
  input logic [NS-1:0]    pe_valid_o,
  input logic [NS-1:0]    pe_ready_i,
  input logic [NS-1:0]    hit_o,
  input logic             vote_valid_o,
  input logic [W-1:0]     vote_op_o,
  input logic [OVF_W-1:0] ovf_cnt_o
);
  localparam logic [OVF_W-1:0] OMAX = '1;

  p_full_not_empty_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~in_ready_o & ~pe_valid_o) == '0));

  p_hit_needs_pop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hit_o & ~(pe_valid_o & pe_ready_i)) == '0));

  p_votes_distinct_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vote_valid_o && $past(vote_valid_o)) |-> (vote_op_o != $past(vote_op_o)));

  p_ovf_monotone_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_cnt_o != OMAX) |=> (ovf_cnt_o >= $past(ovf_cnt_o)));

  p_ovf_saturates_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_cnt_o == OMAX) |=> (ovf_cnt_o == OMAX));
endmodule

bind common_operand_detect cod_checks #(.NS(NS), .W(W), .OVF_W(OVF_W)) i_cod_checks (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_ready_o   (in_ready_o),
  .pe_valid_o   (pe_valid_o),
  .pe_ready_i   (pe_ready_i),
  .hit_o        (hit_o),
  .vote_valid_o (vote_valid_o),
  .vote_op_o    (vote_op_o),
  .ovf_cnt_o    (ovf_cnt_o)
);

// File: tb/test_common_operand_detect.sv
`timescale 1ns/1ps
module test_common_operand_detect;
  localparam int NS = 3, W = 32, DEPTH = 32, NE = 4, OVF_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NS-1:0]        in_valid = '0, pe_ready = '0, res_valid = '0;
  logic [NS-1:0][W-1:0] in_data = '0, res_op = '0, res_data = '0;
  logic [NS-1:0]        in_ready, pe_valid, hit;
  logic [NS-1:0][W-1:0] pe_data, vote_res;
  logic                 vote_valid;
  logic [W-1:0]         vote_op;
  logic [OVF_W-1:0]     ovf;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  common_operand_detect #(.NS(NS), .W(W), .DEPTH(DEPTH), .NE(NE), .OVF_W(OVF_W))
  i_common_operand_detect (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_ready_o(in_ready), .pe_valid_o(pe_valid), .pe_data_o(pe_data),
    .pe_ready_i(pe_ready), .hit_o(hit), .res_valid_i(res_valid), .res_op_i(res_op),
    .res_data_i(res_data), .vote_valid_o(vote_valid), .vote_op_o(vote_op),
    .vote_res_o(vote_res), .ovf_cnt_o(ovf));

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input int k, input logic [W-1:0] d);
    @(negedge clk);
    in_valid[k] = 1'b1; in_data[k] = d;
    @(negedge clk);
    in_valid[k] = 1'b0;
  endtask

  task automatic pop(input int k, input logic [W-1:0] d, input logic h, input string tag);
    @(negedge clk);
    pe_ready[k] = 1'b1;
    #1;
    chk({tag, " R1 valid"}, W'(pe_valid[k]), 1);
    chk({tag, " R1 data"}, pe_data[k], d);
    chk({tag, " R3 hit"}, W'(hit[k]), W'(h));
    @(negedge clk);
    pe_ready[k] = 1'b0;
  endtask

  task automatic result(input int k, input logic [W-1:0] op, input logic [W-1:0] r);
    @(negedge clk);
    res_valid[k] = 1'b1; res_op[k] = op; res_data[k] = r;
    @(negedge clk);
    res_valid[k] = 1'b0;
  endtask

  task automatic expect_vote(input logic [W-1:0] op, input logic [W-1:0] r0,
                             input logic [W-1:0] r1, input logic [W-1:0] r2, input string tag);
    chk({tag, " R6 no early vote"}, W'(vote_valid), 0);
    @(negedge clk);
    chk({tag, " R6 vote"}, W'(vote_valid), 1);
    chk({tag, " R6 op"}, vote_op, op);
    chk({tag, " R6 res0"}, vote_res[0], r0);
    chk({tag, " R7 res1"}, vote_res[1], r1);
    chk({tag, " R6 res2"}, vote_res[2], r2);
    @(negedge clk);
    chk({tag, " R6 single pulse"}, W'(vote_valid), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R11 pe_valid", W'(pe_valid), 0);
    chk("R11 in_ready", W'(in_ready), 3'b111);
    chk("R11 vote_valid", W'(vote_valid), 0);
    chk("R11 ovf", W'(ovf), 0);
  endtask

  task automatic t_order();
    for (int i = 0; i < DEPTH; i++) push(0, 32'h100 + i);
    chk("R2 full ready low", W'(in_ready[0]), 0);
    push(0, 32'hDEAD_0000);
    for (int i = 0; i < DEPTH; i++) pop(0, 32'h100 + i, 1'b0, "order");
    @(negedge clk);
    chk("R1 empty after drain", W'(pe_valid[0]), 0);
    chk("R2 dropped word absent", W'(in_ready[0]), 1);
  endtask

  task automatic t_basic();
    logic [W-1:0] a = 32'h8888_FFFF, b = 32'h0000_BBBB;
    push(1, a); push(2, a); push(0, a);
    pop(0, a, 1'b1, "basic s0 R5");
    result(0, a, 32'h1111);
    pop(1, a, 1'b1, "basic s1 R4 R9");
    result(1, a, 32'h2222);
    result(1, a, 32'hBAD1);
    result(2, 32'h7777_7777, 32'hBAD2);
    @(negedge clk);
    chk("R7 unmatched result no vote", W'(vote_valid), 0);
    pop(2, a, 1'b0, "basic s2 released R3");
    result(2, a, 32'h3333);
    expect_vote(a, 32'h1111, 32'h2222, 32'h3333, "basic");
    push(0, b); push(0, b);
    pop(0, b, 1'b0, "own only R3");
    pop(0, b, 1'b0, "own only R3");
  endtask

  task automatic t_dup();
    logic [W-1:0] d = 32'hD0D0_0001;
    push(0, d); push(1, d); push(2, d);
    @(negedge clk);
    pe_ready[0] = 1'b1; pe_ready[1] = 1'b1;
    #1;
    chk("R9 dup hit0", W'(hit[0]), 1);
    chk("R9 dup hit1", W'(hit[1]), 1);
    @(negedge clk);
    pe_ready = '0;
    pop(2, d, 1'b0, "dup s2");
    result(0, d, 32'hA0); result(1, d, 32'hA1); result(2, d, 32'hA2);
    expect_vote(d, 32'hA0, 32'hA1, 32'hA2, "dup R9");
    chk("R9 no overflow on dup", W'(ovf), 0);
  endtask

  task automatic t_full();
    logic [W-1:0] q = 32'h0C0C_0C0C;
    for (int i = 0; i < 8; i++) begin
      push(0, 32'hF000 + i); push(1, 32'hF000 + i);
      pop(0, 32'hF000 + i, 1'b1, "fill");
      chk("R8 overflow count", W'(ovf), (i < 4) ? 0 : ((i - 3 > 3) ? 3 : i - 3));
    end
    result(0, 32'hF004, 1); result(1, 32'hF004, 2); result(2, 32'hF004, 3);
    @(negedge clk);
    chk("R8 lost hit never votes", W'(vote_valid), 0);
    @(negedge clk);
    chk("R8 lost hit never votes", W'(vote_valid), 0);
    for (int i = 0; i < 8; i++) pop(1, 32'hF000 + i, 1'b0, "drain s1");
    result(0, 32'hF000, 32'h10); result(1, 32'hF000, 32'h11); result(2, 32'hF000, 32'h12);
    expect_vote(32'hF000, 32'h10, 32'h11, 32'h12, "full slot0");
    push(0, q); push(1, q);
    pop(0, q, 1'b1, "R10 realloc");
    pop(1, q, 1'b0, "R10 realloc s1");
    result(0, q, 32'h20); result(1, q, 32'h21); result(2, q, 32'h22);
    expect_vote(q, 32'h20, 32'h21, 32'h22, "R10 reuse");
    chk("R8 saturated", W'(ovf), 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_order();
    t_basic();
    t_dup();
    t_full();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule